// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns a virtual address into a final page-table entry. It walks a radix page table held in memory. A walk starts from the table base register supplied with the request and makes one memory read per level, starting at the top level and working downward. The walk stops at the first entry that is a valid leaf. It also stops at an entry that is neither a leaf nor a pointer, or when the next entry address would fall outside physical memory. A leaf found above the lowest level maps a large page. The walker adds the low virtual-page-number bits below that level to the returned page number, so the result always describes the single base page that was asked for.

With translation switched off, no memory is read. The walker returns an identity entry that grants every permission and is valid only for addresses below the memory size. Requests come in through a valid/ready handshake and only one is in flight at a time. The result, a 64-bit entry plus a fault flag, is held until the consumer accepts it.

Top module: `ptw_walker`

## Requirements
- R1: After reset the walker is ready for a request, issues no memory read and presents no result.
- R2: Once a request is accepted, `req_ready_o` stays low until its result has been accepted.
- R3: With translation on, each level costs exactly one 8-byte read. Reads start at level 2 and go down. The entry address at level L is base + 8 * vaddr[12+9L +: 9], so level 2 uses vaddr[38:30], level 1 uses [29:21] and level 0 uses [20:12].
- R4: Entry format: bit 0 is the table-pointer flag and bit 1 is the valid-leaf flag. Bits 2 to 9 are referenced, dirty, user exec/write/read and supervisor exec/write/read. Bits 10 to 11 are spare, and bits 63:12 hold the physical page number. An entry with bit 1 set ends the walk and is returned without a fault, even when bit 0 is also set.
- R5: A leaf found at level L > 0 is returned with the low 9*L bits of the virtual page number (vaddr >> 12) added to its page number.
- R6: An entry with both bit 0 and bit 1 clear ends the walk, and that entry is returned unchanged with a fault. A pointer entry met at level 0 is also returned unchanged with a fault.
- R7: A pointer entry above level 0 makes the next level's base equal to its page number shifted left by 12.
- R8: If an entry address is at or above `MEM_SIZE`, no read is issued. The walk ends with an all-zero entry and a fault.
- R9: With translation off, the result has bit 0 clear, bit 1 equal to (vaddr < `MEM_SIZE`), bits 2 to 3 clear, bits 4 to 9 set and page number vaddr >> 12. No memory read is made.
- R10: `rsp_fault_o` is high exactly when bit 1 of the returned entry is clear.
- R11: While `rsp_valid_o` is high and `rsp_ready_i` is low, the result and fault flag stay unchanged.
- R12: A memory read request, once raised, keeps its address and stays raised until `mem_req_ready_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle and able to accept a request |
| req_vaddr_i | input | 39 | Virtual address to translate |
| ptbr_i | input | 32 | Physical byte address of the top-level table |
| vm_en_i | input | 1 | Translation enable; low selects identity mapping |
| mem_req_valid_o | output | 1 | Memory read request |
| mem_req_ready_i | input | 1 | Memory accepts the read request |
| mem_addr_o | output | 32 | Byte address of the entry to read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 64 | Read data (one entry) |
| rsp_valid_o | output | 1 | Result valid (walk done) |
| rsp_ready_i | input | 1 | Consumer accepts the result |
| rsp_fault_o | output | 1 | Access fault for this translation |
| rsp_pte_o | output | 64 | Resulting entry |

## Verification
The assertions assume a memory port that returns exactly one response for each accepted read, and only after the read was accepted. They also assume the request inputs are sampled only on the accepting edge. The bench memory model answers every accepted read once, two edges later. It drops its ready line in a fixed pattern, which exercises request holding. The bench drives the request fields only while `req_valid_i` is high and changes them only after the accepting edge. Page tables in the model are laid out so every walk, including the out-of-range one, ends within three reads.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned PTE_W   = 64;
  localparam int unsigned PPN_LSB = 12;
  localparam int unsigned PPN_W   = PTE_W - PPN_LSB;

  localparam int unsigned B_PTR = 0;  // points to next table
  localparam int unsigned B_LEAF = 1; // valid leaf
  localparam int unsigned B_REF = 2;
  localparam int unsigned B_DIRTY = 3;
  localparam int unsigned B_PERM_LO = 4;
  localparam int unsigned PERM_N = 6;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } walk_state_e;
endpackage

// File: rtl/ptw_index_calc.sv
module ptw_index_calc #(
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned ENTRY_LG   = 3,
  parameter int unsigned LEVELS     = 3,
  localparam int unsigned IDX_W = PAGE_SHIFT - ENTRY_LG,
  localparam int unsigned VA_W  = PAGE_SHIFT + LEVELS * IDX_W,
  localparam int unsigned LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [63:0]      base_i,
  output logic [63:0]      pte_addr_o
);
  logic [IDX_W-1:0] idx;

  always_comb begin
    idx = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (level_i == LVL_W'(l)) idx = vaddr_i[PAGE_SHIFT + l*IDX_W +: IDX_W];
    end
    pte_addr_o = base_i + (64'(idx) << ENTRY_LG);
  end
endmodule

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval
  import ptw_pkg::*;
#(
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned ENTRY_LG   = 3,
  parameter int unsigned LEVELS     = 3,
  localparam int unsigned IDX_W = PAGE_SHIFT - ENTRY_LG,
  localparam int unsigned VA_W  = PAGE_SHIFT + LEVELS * IDX_W,
  localparam int unsigned LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic [PTE_W-1:0] pte_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [VA_W-1:0]  vaddr_i,
  output logic             is_leaf_o,
  output logic             is_ptr_o,
  output logic [PTE_W-1:0] leaf_pte_o,
  output logic [63:0]      next_base_o
);
  logic [63:0]    vpn;
  logic [63:0]    fold_mask;
  logic [PPN_W-1:0] ppn_sum;

  always_comb begin
    vpn       = 64'(vaddr_i) >> PAGE_SHIFT;
    fold_mask = '0;
    for (int l = 1; l < LEVELS; l++) begin
      if (level_i == LVL_W'(l)) fold_mask = (64'd1 << (l * IDX_W)) - 64'd1;
    end
    // superpage: fold low vpn bits so result names one base page
    ppn_sum     = pte_i[PTE_W-1:PPN_LSB] + PPN_W'(vpn & fold_mask);
    leaf_pte_o  = {ppn_sum, pte_i[PPN_LSB-1:0]};
    next_base_o = 64'(pte_i[PTE_W-1:PPN_LSB]) << PAGE_SHIFT;
    is_leaf_o   = pte_i[B_LEAF];
    is_ptr_o    = pte_i[B_PTR];
  end
endmodule

// File: rtl/ptw_bypass.sv
module ptw_bypass
  import ptw_pkg::*;
#(
  parameter int unsigned    VA_W       = 39,
  parameter int unsigned    PAGE_SHIFT = 12,
  parameter logic [63:0]    MEM_SIZE   = 64'h10_0000
) (
  input  logic [VA_W-1:0]  vaddr_i,
  output logic [PTE_W-1:0] pte_o
);
  logic [63:0] va64;

  always_comb begin
    va64                             = 64'(vaddr_i);
    pte_o                            = '0;
    pte_o[B_LEAF]                    = va64 < MEM_SIZE;
    pte_o[B_PERM_LO +: PERM_N]       = '1;
    pte_o[PTE_W-1:PPN_LSB]           = PPN_W'(va64 >> PAGE_SHIFT);
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned ENTRY_LG   = 3,
  parameter int unsigned LEVELS     = 3,
  parameter int unsigned PA_W       = 32,
  parameter logic [63:0] MEM_SIZE   = 64'h10_0000,
  localparam int unsigned IDX_W = PAGE_SHIFT - ENTRY_LG,
  localparam int unsigned VA_W  = PAGE_SHIFT + LEVELS * IDX_W,
  localparam int unsigned LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic [PA_W-1:0]  ptbr_i,
  input  logic             vm_en_i,
  output logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  output logic [PA_W-1:0]  mem_addr_o,
  input  logic             mem_rsp_valid_i,
  input  logic [PTE_W-1:0] mem_rsp_data_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic             rsp_fault_o,
  output logic [PTE_W-1:0] rsp_pte_o
);
  walk_state_e      state_q;
  logic [VA_W-1:0]  vaddr_q;
  logic [63:0]      base_q;
  logic [LVL_W-1:0] level_q;
  logic [PTE_W-1:0] pte_q;
  logic             fault_q;

  logic [63:0]      pte_addr;
  logic             addr_ok;
  logic             is_leaf, is_ptr;
  logic [PTE_W-1:0] leaf_pte, bypass_pte;
  logic [63:0]      next_base;

  ptw_index_calc #(
    .PAGE_SHIFT(PAGE_SHIFT), .ENTRY_LG(ENTRY_LG), .LEVELS(LEVELS)
  ) u_index (
    .vaddr_i(vaddr_q), .level_i(level_q), .base_i(base_q), .pte_addr_o(pte_addr)
  );

  ptw_pte_eval #(
    .PAGE_SHIFT(PAGE_SHIFT), .ENTRY_LG(ENTRY_LG), .LEVELS(LEVELS)
  ) u_eval (
    .pte_i(mem_rsp_data_i), .level_i(level_q), .vaddr_i(vaddr_q),
    .is_leaf_o(is_leaf), .is_ptr_o(is_ptr),
    .leaf_pte_o(leaf_pte), .next_base_o(next_base)
  );

  ptw_bypass #(
    .VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT), .MEM_SIZE(MEM_SIZE)
  ) u_bypass (
    .vaddr_i(req_vaddr_i), .pte_o(bypass_pte)
  );

  assign addr_ok         = pte_addr < MEM_SIZE;
  assign req_ready_o     = state_q == ST_IDLE;
  assign mem_req_valid_o = (state_q == ST_ISSUE) && addr_ok;
  assign mem_addr_o      = pte_addr[PA_W-1:0];
  assign rsp_valid_o     = state_q == ST_DONE;
  assign rsp_pte_o       = pte_q;
  assign rsp_fault_o     = fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      vaddr_q <= '0;
      base_q  <= '0;
      level_q <= '0;
      pte_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          vaddr_q <= req_vaddr_i;
          base_q  <= 64'(ptbr_i);
          level_q <= LVL_W'(LEVELS - 1);
          if (vm_en_i) begin
            state_q <= ST_ISSUE;
          end else begin
            pte_q   <= bypass_pte;
            fault_q <= ~bypass_pte[B_LEAF];
            state_q <= ST_DONE;
          end
        end
        ST_ISSUE: begin
          if (!addr_ok) begin
            pte_q   <= '0;
            fault_q <= 1'b1;
            state_q <= ST_DONE;
          end else if (mem_req_ready_i) begin
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: if (mem_rsp_valid_i) begin
          if (is_leaf) begin
            pte_q   <= leaf_pte;
            fault_q <= 1'b0;
            state_q <= ST_DONE;
          end else if (is_ptr && level_q != '0) begin
            base_q  <= next_base;
            level_q <= level_q - 1'b1;
            state_q <= ST_ISSUE;
          end else begin
            // neither flag, or pointer at last level
            pte_q   <= mem_rsp_data_i;
            fault_q <= 1'b1;
            state_q <= ST_DONE;
          end
        end
        ST_DONE: if (rsp_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o); // R2
  AST_MEM_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> mem_addr_o[ENTRY_LG-1:0] == '0); // R3
  AST_MEM_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> 64'(mem_addr_o) < MEM_SIZE); // R8
  AST_RSP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_pte_o) && $stable(rsp_fault_o)); // R11
  AST_MEM_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_addr_o)); // R12
  AST_NO_REQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_valid_o && !rsp_valid_o); // R1
endmodule

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [38:0] req_vaddr = '0;
  logic [31:0] ptbr = '0;
  logic        vm_en = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic        rsp_fault;
  logic [63:0] rsp_pte;

  int errors = 0;
  int checks = 0;
  int reads = 0;
  int hold_errs = 0;
  int hold_checks = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  ptw_walker dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_vaddr_i(req_vaddr), .ptbr_i(ptbr), .vm_en_i(vm_en),
    .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready),
    .mem_addr_o(mem_addr), .mem_rsp_valid_i(mem_rsp_valid),
    .mem_rsp_data_i(mem_rsp_data), .rsp_valid_o(rsp_valid),
    .rsp_ready_i(rsp_ready), .rsp_fault_o(rsp_fault), .rsp_pte_o(rsp_pte)
  );

  function automatic logic [63:0] mem_lookup(input logic [31:0] a);
    case (a)
      32'h1000: return 64'h2001;        // L2[0] -> table 0x2000
      32'h1008: return 64'h4000_03F2;   // L2[1] leaf, ppn 0x40000
      32'h1018: return 64'h20_0001;     // L2[3] -> table beyond memory
      32'h2000: return 64'h3001;        // L1[0] -> table 0x3000
      32'h2008: return 64'h100_0062;    // L1[1] leaf, ppn 0x1000
      32'h3000: return 64'h5_520E;      // L0[0] leaf, ppn 0x55
      32'h3008: return 64'h7_7001;      // L0[1] pointer at last level
      32'h3028: return 64'h9_9003;      // L0[5] leaf and pointer
      default:  return 64'h0;
    endcase
  endfunction

  // memory model: answers each accepted read two edges later
  logic        pend = 1'b0;
  logic [63:0] pend_data = '0;
  logic        prev_stall = 1'b0;
  logic [31:0] prev_addr = '0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rsp_valid <= 1'b0;
    if (pend) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= pend_data;
      pend          <= 1'b0;
    end
    if (prev_stall) begin
      hold_checks <= hold_checks + 1;
      if (!mem_req_valid || mem_addr != prev_addr) begin
        hold_errs <= hold_errs + 1;
        $display("FAIL R12 read request dropped: valid=%0b addr=%h exp addr=%h",
                 mem_req_valid, mem_addr, prev_addr);
      end
    end
    prev_stall <= mem_req_valid && !mem_req_ready;
    prev_addr  <= mem_addr;
    if (mem_req_valid && mem_req_ready) begin
      pend      <= 1'b1;
      pend_data <= mem_lookup(mem_addr);
      reads     <= reads + 1;
    end
    mem_req_ready <= (cyc % 3) != 1;
  end

  typedef struct packed {
    logic [7:0]  req;
    logic [38:0] vaddr;
    logic [31:0] base;
    logic        vm;
    logic [3:0]  hold;
    logic [63:0] pte;
    logic        fault;
    logic [3:0]  nreads;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{8'd3,  39'h123,        32'h1000,   1'b1, 4'd0, 64'h5_520E,     1'b0, 4'd3}, // R3
    '{8'd6,  39'h1000,       32'h1000,   1'b1, 4'd0, 64'h7_7001,     1'b1, 4'd3}, // R6
    '{8'd4,  39'h5000,       32'h1000,   1'b1, 4'd0, 64'h9_9003,     1'b0, 4'd3}, // R4
    '{8'd5,  39'h23_3456,    32'h1000,   1'b1, 4'd3, 64'h103_3062,   1'b0, 4'd2}, // R5
    '{8'd5,  39'h40A0_7000,  32'h1000,   1'b1, 4'd0, 64'h40A0_73F2,  1'b0, 4'd1}, // R5
    '{8'd6,  39'h8000_0000,  32'h1000,   1'b1, 4'd0, 64'h0,          1'b1, 4'd1}, // R6
    '{8'd8,  39'hC000_0000,  32'h1000,   1'b1, 4'd0, 64'h0,          1'b1, 4'd1}, // R8
    '{8'd9,  39'h1_2345,     32'h1000,   1'b0, 4'd2, 64'h1_23F2,     1'b0, 4'd0}, // R9
    '{8'd9,  39'h10_0000,    32'h1000,   1'b0, 4'd0, 64'h10_03F0,    1'b1, 4'd0}, // R9
    '{8'd9,  39'hF_FFFF,     32'h1000,   1'b0, 4'd0, 64'hF_F3F2,     1'b0, 4'd0}, // R9
    '{8'd8,  39'h123,        32'h10_0000,1'b1, 4'd0, 64'h0,          1'b1, 4'd0}, // R8
    '{8'd7,  39'h40_0000,    32'h1000,   1'b1, 4'd0, 64'h0,          1'b1, 4'd2}  // R7
  };

  task automatic check(input bit ok, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic walk(input vec_t v);
    int r0;
    int to;
    @(negedge clk);
    req_vaddr = v.vaddr;
    ptbr      = v.base;
    vm_en     = v.vm;
    req_valid = 1'b1;
    to = 0;
    while (!req_ready && to < 100) begin @(negedge clk); to++; end
    r0 = reads;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R2 ready while busy", 64'(req_ready), 64'd0);
    to = 0;
    while (!rsp_valid && to < 200) begin @(negedge clk); to++; end
    check(rsp_valid, "R2 walk never finished", 64'(rsp_valid), 64'd1);
    for (int h = 0; h < int'(v.hold); h++) begin
      @(negedge clk);
      check(rsp_valid && rsp_pte == v.pte, "R11 result not held", rsp_pte, v.pte);
      check(!req_ready, "R2 ready before result taken", 64'(req_ready), 64'd0);
    end
    checks++;
    if (rsp_pte != v.pte) begin
      errors++;
      $display("FAIL R%0d entry for vaddr %h actual=%h expected=%h",
               v.req, v.vaddr, rsp_pte, v.pte);
    end
    check(rsp_fault == v.fault, "R10 fault flag", 64'(rsp_fault), 64'(v.fault));
    check(rsp_fault == ~rsp_pte[1], "R10 fault vs leaf bit", 64'(rsp_fault), 64'(~rsp_pte[1]));
    check((reads - r0) == int'(v.nreads), "R3 read count", 64'(reads - r0), 64'(v.nreads));
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check(!rsp_valid && req_ready, "R11 result not released", 64'(rsp_valid), 64'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors + hold_errs, checks + hold_checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(req_ready, "R1 ready after reset", 64'(req_ready), 64'd1);
    check(!mem_req_valid, "R1 no read in reset", 64'(mem_req_valid), 64'd0);
    check(!rsp_valid, "R1 no result in reset", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !rsp_valid && !mem_req_valid, "R1 idle after reset",
          {61'd0, req_ready, rsp_valid, mem_req_valid}, 64'd4);
    for (int i = 0; i < NV; i++) walk(VEC[i]);
    // back-to-back repeat of the deepest walk after a result was taken
    walk(VEC[0]);
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors + hold_errs, checks + hold_checks);
    $finish;
  end
endmodule